// File: doc/BRIEF.md
# Cache-Aware Warp Priority Scheduler

This block picks one warp per cycle to issue from a set of ready warps. Its base policy is greedy-then-oldest. The warp issued in the previous cycle is issued again while it stays ready and eligible. Otherwise the oldest eligible ready warp wins. Each warp carries a flag that marks its current load as streaming, meaning the load bypasses the L1 data cache. The flags split the warps into a streaming group and a cached group.

Alongside the picker, a health monitor counts L1 hit events, L1 miss events and pipeline-stall cycles over a fixed sampling window. A configured L2 latency value is supplied beside these counts. At the end of each window the monitor weighs the benefit of hits (hits times L2 latency) against the cost of misses (misses times stall). It does this by cross-multiplication rather than division. When the cache looks healthy, the cached group is favoured. When the cache looks contended, the streaming group is favoured. In the band between the two, no group is favoured. The monitor then clears its counts for the next window.

Top module: `cache_aware_warp_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `issue_valid` is 0 and `prio_mode` is 0 (neutral).
- R2: The issue decision is registered. After each clock edge, `issue_valid` is 1 exactly when at least one bit of `warp_ready` was set before that edge, and the named warp was then ready.
- R3: If the previous cycle issued warp w, and w is still ready and in the eligible set, w is issued again, even when an older warp is ready.
- R4: Otherwise the eligible ready warp with the largest `warp_age` is issued. A larger age means older. On equal ages, the lowest warp index wins.
- R5: Events are counted over windows of `WINDOW` cycles. `prio_mode` changes only at the edge that closes a window, and the counts restart at zero after it. An event presented in the closing cycle of a window is not counted.
- R6: A window closes with `prio_mode` = 1 (favour cached warps, `warp_stream` = 0) when hits·latency > misses·stall.
- R7: A window closes with `prio_mode` = 2 (favour streaming warps, `warp_stream` = 1) when 5·hits·latency < misses·stall and R6 does not apply.
- R8: A window closes with `prio_mode` = 0 when neither R6 nor R7 holds. This includes the case where both products are equal and the case where all counts are zero. In mode 0 all ready warps are eligible.
- R9: In modes 1 and 2 only ready warps of the favoured group are eligible. If that group has no ready warp, all ready warps are eligible.
- R10: Each event count saturates at 2^`CNT_W`−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | N_WARPS | Per-warp ready-to-issue flags |
| warp_stream | input | N_WARPS | Per-warp flag: current load bypasses L1 |
| warp_age | input | N_WARPS*AGE_W | Per-warp age, warp i in bits [i*AGE_W +: AGE_W], larger is older |
| hit_evt | input | 1 | One L1 hit this cycle |
| miss_evt | input | 1 | One L1 miss this cycle |
| stall_evt | input | 1 | Pipeline stalled this cycle |
| l2_latency | input | LAT_W | Configured L2 access latency in cycles |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | $clog2(N_WARPS) | Index of the issued warp |
| prio_mode | output | 2 | 0 neutral, 1 favour cached, 2 favour streaming |

## Verification
Two functions can fall on the same edge: the window-closing mode update, and the greedy reissue rule. A mode flip must therefore override greedy continuation. The bench provokes this in two ways. First, it runs a streaming-favoured window and then asks for a pick right after a cached warp was issued. The cached warp is judged correct only if it loses to a ready streaming warp. Second, it places a hit pulse exactly on the closing edge of a window. That pulse is judged correct only if the mode stays neutral.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    PRIO_NEUTRAL = 2'd0,
    PRIO_CACHED  = 2'd1,
    PRIO_STREAM  = 2'd2
  } prio_mode_e;

  localparam int unsigned EVT_HIT   = 0;
  localparam int unsigned EVT_MISS  = 1;
  localparam int unsigned EVT_STALL = 2;
  localparam int unsigned EVT_NUM   = 3;
endpackage

// File: rtl/wps_health_monitor.sv
module wps_health_monitor
  import wps_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LAT_W  = 10,
  parameter int unsigned WINDOW = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_evt,
  input  logic             miss_evt,
  input  logic             stall_evt,
  input  logic [LAT_W-1:0] l2_latency,
  output prio_mode_e       mode
);
  localparam int unsigned WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
  localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam int unsigned BEN_W = CNT_W + LAT_W + 3;
  localparam int unsigned CST_W = 2 * CNT_W;
  localparam int unsigned CMP_W = ((BEN_W > CST_W) ? BEN_W : CST_W) + 1;

  logic [WIN_W-1:0] win_cnt;
  logic             win_end;
  logic [EVT_NUM-1:0] evt;
  logic [CNT_W-1:0] cnt [EVT_NUM];
  logic             past_ok;

  assign win_end = (win_cnt == WIN_LAST);
  assign evt     = {stall_evt, miss_evt, hit_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      win_cnt <= win_end ? '0 : win_cnt + WIN_ONE;
    end
  end

  // One saturating counter per event kind
  for (genvar k = 0; k < EVT_NUM; k++) begin : g_evt_cnt
    always_ff @(posedge clk) begin
      if (rst || win_end) begin
        cnt[k] <= '0;
      end else if (evt[k] && (cnt[k] != CNT_MAX)) begin
        cnt[k] <= cnt[k] + CNT_ONE;
      end
    end

    // R10: a full count stays full until the window closes
    p_cnt_saturate_r10 : assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(win_end) && ($past(cnt[k]) == CNT_MAX)) |-> (cnt[k] == CNT_MAX));

    // R5: counts restart after a closing edge
    p_cnt_clear_r5 : assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(win_end)) |-> (cnt[k] == '0));
  end

  logic [CMP_W-1:0] benefit, benefit5, cost;
  prio_mode_e       mode_nxt;

  always_comb begin
    benefit  = {{(CMP_W-CNT_W){1'b0}}, cnt[EVT_HIT]} * {{(CMP_W-LAT_W){1'b0}}, l2_latency};
    benefit5 = (benefit << 2) + benefit;
    cost     = {{(CMP_W-CNT_W){1'b0}}, cnt[EVT_MISS]} * {{(CMP_W-CNT_W){1'b0}}, cnt[EVT_STALL]};
    if (benefit > cost)       mode_nxt = PRIO_CACHED;
    else if (benefit5 < cost) mode_nxt = PRIO_STREAM;
    else                      mode_nxt = PRIO_NEUTRAL;
  end

  always_ff @(posedge clk) begin
    if (rst)          mode <= PRIO_NEUTRAL;
    else if (win_end) mode <= mode_nxt;
  end

  // R5: mode only moves at a window boundary
  p_mode_hold_r5 : assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(win_end)) |-> $stable(mode));

  // R8: the mode never takes the unused encoding
  p_mode_legal_r8 : assert property (@(posedge clk) disable iff (rst)
    mode != prio_mode_e'(2'd3));
endmodule

// File: rtl/wps_gto_pick.sv
module wps_gto_pick #(
  parameter int unsigned N_WARPS = 8,
  parameter int unsigned AGE_W   = 8,
  localparam int unsigned WID_W  = (N_WARPS > 2) ? $clog2(N_WARPS) : 1
) (
  input  logic [N_WARPS-1:0]       elig,
  input  logic [N_WARPS*AGE_W-1:0] ages,
  input  logic                     prev_valid,
  input  logic [WID_W-1:0]         prev_idx,
  output logic                     any,
  output logic [WID_W-1:0]         idx
);
  logic [AGE_W-1:0] age [N_WARPS];

  for (genvar i = 0; i < N_WARPS; i++) begin : g_unpack
    assign age[i] = ages[i*AGE_W +: AGE_W];
  end

  logic             found;
  logic [AGE_W-1:0] best_age;
  logic [WID_W-1:0] best_idx;

  // Oldest scan; strict compare keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    best_age = '0;
    best_idx = '0;
    for (int i = 0; i < N_WARPS; i++) begin
      if (elig[i] && (!found || (age[i] > best_age))) begin
        found    = 1'b1;
        best_age = age[i];
        best_idx = WID_W'(i);
      end
    end
  end

  assign any = |elig;
  assign idx = (prev_valid && elig[prev_idx]) ? prev_idx : best_idx;
endmodule

// File: rtl/cache_aware_warp_sched.sv
module cache_aware_warp_sched
  import wps_pkg::*;
#(
  parameter int unsigned N_WARPS = 8,
  parameter int unsigned AGE_W   = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LAT_W   = 10,
  parameter int unsigned WINDOW  = 256,
  localparam int unsigned WID_W  = (N_WARPS > 2) ? $clog2(N_WARPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_WARPS-1:0]       warp_ready,
  input  logic [N_WARPS-1:0]       warp_stream,
  input  logic [N_WARPS*AGE_W-1:0] warp_age,
  input  logic                     hit_evt,
  input  logic                     miss_evt,
  input  logic                     stall_evt,
  input  logic [LAT_W-1:0]         l2_latency,
  output logic                     issue_valid,
  output logic [WID_W-1:0]         issue_warp,
  output logic [1:0]               prio_mode
);
  prio_mode_e         mode;
  logic [N_WARPS-1:0] favoured, elig;
  logic               pick_any;
  logic [WID_W-1:0]   pick_idx;
  logic               past_ok;

  wps_health_monitor #(
    .CNT_W (CNT_W),
    .LAT_W (LAT_W),
    .WINDOW(WINDOW)
  ) i_monitor (
    .clk       (clk),
    .rst       (rst),
    .hit_evt   (hit_evt),
    .miss_evt  (miss_evt),
    .stall_evt (stall_evt),
    .l2_latency(l2_latency),
    .mode      (mode)
  );

  always_comb begin
    case (mode)
      PRIO_CACHED: favoured = warp_ready & ~warp_stream;
      PRIO_STREAM: favoured = warp_ready &  warp_stream;
      default:     favoured = warp_ready;
    endcase
    elig = (|favoured) ? favoured : warp_ready;
  end

  wps_gto_pick #(
    .N_WARPS(N_WARPS),
    .AGE_W  (AGE_W)
  ) i_pick (
    .elig      (elig),
    .ages      (warp_age),
    .prev_valid(issue_valid),
    .prev_idx  (issue_warp),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      past_ok     <= 1'b0;
    end else begin
      past_ok     <= 1'b1;
      issue_valid <= pick_any;
      if (pick_any) issue_warp <= pick_idx;
    end
  end

  assign prio_mode = mode;

  logic [N_WARPS-1:0] issue_oh;
  assign issue_oh = N_WARPS'(1) << issue_warp;

  // R2: issue exactly when something was ready, and only a ready warp
  p_issue_iff_ready_r2 : assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (issue_valid == (|$past(warp_ready))));

  p_issue_was_ready_r2 : assert property (@(posedge clk) disable iff (rst)
    (past_ok && issue_valid) |-> (|($past(warp_ready) & issue_oh)));

  // R3: in neutral mode a still-ready warp keeps issuing
  p_greedy_hold_r3 : assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(issue_valid) && ($past(mode) == PRIO_NEUTRAL) &&
     (|($past(warp_ready) & $past(issue_oh)))) |-> (issue_valid && (issue_warp == $past(issue_warp))));

  // R9: with streaming favoured and one ready, a streaming warp goes
  p_stream_pref_r9 : assert property (@(posedge clk) disable iff (rst)
    (past_ok && issue_valid && ($past(mode) == PRIO_STREAM) &&
     (|($past(warp_ready) & $past(warp_stream)))) |-> (|($past(warp_stream) & issue_oh)));

  // R9: with cached favoured and one ready, a cached warp goes
  p_cached_pref_r9 : assert property (@(posedge clk) disable iff (rst)
    (past_ok && issue_valid && ($past(mode) == PRIO_CACHED) &&
     (|($past(warp_ready) & ~$past(warp_stream)))) |-> (|(~$past(warp_stream) & issue_oh)));
endmodule

// File: tb/test_cache_aware_warp_sched.sv
module test_cache_aware_warp_sched;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned CW = 4;
  localparam int unsigned LW = 8;
  localparam int unsigned W  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  warp_ready = '0;
  logic [N-1:0]  warp_stream = '0;
  logic [N*AW-1:0] warp_age = '0;
  logic          hit_evt = 1'b0, miss_evt = 1'b0, stall_evt = 1'b0;
  logic [LW-1:0] l2_latency = 8'd10;
  logic          issue_valid;
  logic [2:0]    issue_warp;
  logic [1:0]    prio_mode;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  cache_aware_warp_sched #(
    .N_WARPS(N), .AGE_W(AW), .CNT_W(CW), .LAT_W(LW), .WINDOW(W)
  ) i_cache_aware_warp_sched (
    .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_stream(warp_stream),
    .warp_age(warp_age), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .stall_evt(stall_evt), .l2_latency(l2_latency), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .prio_mode(prio_mode)
  );

  // {ready, expected valid, expected warp}; ages fixed below, neutral mode
  localparam logic [11:0] SEL_VEC [10] = '{
    {8'h00, 1'b0, 3'd0}, {8'hFF, 1'b1, 3'd3}, {8'hFF, 1'b1, 3'd3},
    {8'hF7, 1'b1, 3'd5}, {8'hFF, 1'b1, 3'd5}, {8'h01, 1'b1, 3'd0},
    {8'h81, 1'b1, 3'd0}, {8'h80, 1'b1, 3'd7}, {8'h00, 1'b0, 3'd0},
    {8'h06, 1'b1, 3'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_age(input int w, input int v);
    warp_age[w*AW +: AW] = AW'(v);
  endtask

  task automatic pick(input logic [7:0] rdy, input string req, input int exp_w);
    warp_ready = rdy;
    @(posedge clk); @(negedge clk);
    chk(req, int'(issue_valid), 1);
    chk(req, int'(issue_warp), exp_w);
  endtask

  task automatic wait_align();
    while (cyc % W != 0) @(negedge clk);
  endtask

  task automatic run_window(input int h, input int m, input int s, input bit last_only,
                            input string req, input int exp_mode);
    wait_align();
    warp_ready = '0;
    for (int i = 0; i < W; i++) begin
      hit_evt   = last_only ? (i == W - 1) : (i < h);
      miss_evt  = (i < m);
      stall_evt = (i < s);
      @(posedge clk); @(negedge clk);
    end
    hit_evt = 1'b0; miss_evt = 1'b0; stall_evt = 1'b0;
    chk(req, int'(prio_mode), exp_mode);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_age(0, 10); set_age(1, 50); set_age(2, 30); set_age(3, 70);
    set_age(4, 20); set_age(5, 60); set_age(6, 40); set_age(7, 5);
    warp_stream = 8'h0A;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(issue_valid), 0);
    chk("R1 reset mode", int'(prio_mode), 0);
    rst = 1'b0;

    // R2 R3 R4: table of neutral-mode picks
    for (int k = 0; k < 10; k++) begin
      warp_ready = SEL_VEC[k][11:4];
      @(posedge clk); @(negedge clk);
      chk("R2 valid", int'(issue_valid), int'(SEL_VEC[k][3]));
      if (SEL_VEC[k][3]) chk("R3/R4 warp", int'(issue_warp), int'(SEL_VEC[k][2:0]));
    end
    warp_ready = '0;

    // R4 tie: equal ages, lowest index wins
    set_age(2, 99); set_age(6, 99);
    @(negedge clk);
    pick(8'h44, "R4 tie", 2);
    warp_ready = '0;
    set_age(2, 30); set_age(6, 40);

    // R5: hit on the closing edge is dropped
    run_window(0, 0, 0, 1'b1, "R5 closing-cycle event", 0);

    // R6: 10*10=100 > 5*5=25
    run_window(10, 5, 5, 1'b0, "R6 cached mode", 1);
    pick(8'hFF, "R9 cached oldest", 5);
    pick(8'h0A, "R9 cached fallback", 3);
    pick(8'hFF, "R9 cached overrides greedy", 5);
    warp_ready = '0;

    // R8: 5*20=100 == 100, lower bound equality
    run_window(2, 10, 10, 1'b0, "R8 lower equal", 0);
    // R8: 50 == 50, upper bound equality
    run_window(5, 5, 10, 1'b0, "R8 upper equal", 0);

    // R7: 5*20=100 < 110
    run_window(2, 11, 10, 1'b0, "R7 stream mode", 2);
    pick(8'hFF, "R9 stream oldest", 3);
    pick(8'hF7, "R9 stream next", 1);
    pick(8'hF5, "R9 stream fallback", 5);
    pick(8'hFF, "R9 stream overrides greedy", 3);
    warp_ready = '0;

    // R8: all counts zero
    run_window(0, 0, 0, 1'b0, "R8 zero counts", 0);

    // R10: miss and stall saturate at 15: 5*30=150 < 225 (wrapped would be 16)
    l2_latency = 8'd2;
    run_window(15, 20, 20, 1'b0, "R10 saturation", 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule